// File: doc/BRIEF.md
# Instrument Status Reporting Registers

This block holds the status-reporting state of a measurement instrument. Three groups of live condition inputs (standard, operation and questionable) are watched for rising edges. Each edge sets a sticky bit in that group's event register. Each event register has its own enable mask. The OR of event AND enable for each group forms a summary bit in an 8-bit status byte.

Two further status byte bits follow external inputs directly. One shows that the output buffer holds unread data. The other shows that the error queue is non-empty. A master summary bit is raised whenever any summary bit is also selected by the service-request enable mask.

A host reaches the block through a simple single-cycle register port. Reading an event register returns its contents and clears it. The host can write and read back the enable masks, and it can read the status byte without side effects. A separate clear-all strobe empties every event register at once.

Top module: `status_report_regs`

## Requirements
- R1: The status byte carries the operation summary on bit 7, the standard summary on bit 5, the output-buffer-not-empty flag on bit 4, the questionable summary on bit 3 and the error-queue-not-empty flag on bit 2. Bits 1 and 0 are always 0. Each group summary is the OR over that group of (event bit AND enable bit).
- R2: An event bit is set by a 0-to-1 change of its condition bit and stays set after the condition falls. A condition that stays high does not set its event bit again once it has been cleared.
- R3: A host read of an event register returns its contents in the same cycle and clears that register at the end of the access. Address 0 is the standard group, 1 the operation group and 2 the questionable group.
- R4: If a rising condition edge lands in the same cycle as a clearing read of its event register, the new event bit is kept.
- R5: Status byte bit 6 is 1 exactly when some status byte bit is 1 and the matching bit of the service-request enable mask (address 6) is also 1. Bit 6 of that mask is ignored on write and reads back as 0. The master bit falls when its source event is cleared or its enable bit is removed.
- R6: A read of the status byte (address 7) returns it in bits 7:0 and clears nothing.
- R7: A one-cycle clear-all pulse empties all three event registers and leaves every enable mask unchanged.
- R8: Status byte bits 4 and 2 follow the output-buffer and error-queue inputs in the same cycle, with no latching.
- R9: Writes to addresses 3, 4, 5 and 6 load the standard, operation, questionable and service-request enable masks. These masks read back at the same addresses, and writing 0 to a mask clears it.
- R10: After reset, every event register and every enable mask is zero, and so is the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stdCond | input | STD_W | Live standard-group conditions |
| operCond | input | OPER_W | Live operation-group conditions |
| quesCond | input | QUES_W | Live questionable-group conditions |
| outBufNonEmpty | input | 1 | Output buffer holds unread data |
| errQueueNonEmpty | input | 1 | Error queue holds entries |
| hostValid | input | 1 | Host access this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | Register address |
| hostWdata | input | DATA_W | Write data |
| clearAll | input | 1 | Clear-all event strobe |
| hostRdata | output | DATA_W | Read data, valid in the cycle of the read, 0 otherwise |
| statusByte | output | 8 | Live status byte |

## Verification
The bench builds the block with its default widths. These are an 8-bit standard group and 16-bit operation and questionable groups, with a 16-bit data path, so an all-ones mask can be written to a full 16-bit group and read back. Directed tasks place a condition edge on the same clock edge as a clearing read. They hold a condition high across a clear, and they toggle service-request enable bits while a summary is standing, so the master bit's set and drop paths and the ignored mask bit are all observed at the status byte.

// File: rtl/status_pkg.sv
`timescale 1ns/1ps
package status_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STD_EV   = 3'd0,
    ADDR_OPER_EV  = 3'd1,
    ADDR_QUES_EV  = 3'd2,
    ADDR_STD_EN   = 3'd3,
    ADDR_OPER_EN  = 3'd4,
    ADDR_QUES_EN  = 3'd5,
    ADDR_SRQ_EN   = 3'd6,
    ADDR_STATUS   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic rdStd;
    logic rdOper;
    logic rdQues;
    logic wrStdEn;
    logic wrOperEn;
    logic wrQuesEn;
    logic wrSrqEn;
    logic clrAll;
  } strobe_t;

  // bit 6 of the service-request mask never takes part
  localparam logic [7:0] SRQ_KEEP = 8'hBF;
endpackage

// File: rtl/status_ctrl.sv
`timescale 1ns/1ps
module status_ctrl
  import status_pkg::*;
(
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              clearAll,
  output strobe_t           strb
);
  logic isRead;
  logic isWrite;

  assign isRead  = hostValid && !hostWrite;
  assign isWrite = hostValid && hostWrite;

  always_comb begin
    strb          = '0;
    strb.clrAll   = clearAll;
    strb.rdStd    = isRead  && (hostAddr == ADDR_STD_EV);
    strb.rdOper   = isRead  && (hostAddr == ADDR_OPER_EV);
    strb.rdQues   = isRead  && (hostAddr == ADDR_QUES_EV);
    strb.wrStdEn  = isWrite && (hostAddr == ADDR_STD_EN);
    strb.wrOperEn = isWrite && (hostAddr == ADDR_OPER_EN);
    strb.wrQuesEn = isWrite && (hostAddr == ADDR_QUES_EN);
    strb.wrSrqEn  = isWrite && (hostAddr == ADDR_SRQ_EN);
  end
endmodule

// File: rtl/status_event_group.sv
`timescale 1ns/1ps
module status_event_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cond,
  input  logic         clrEv,
  input  logic         wrEn,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] evQ,
  output logic [W-1:0] enQ,
  output logic         summary
);
  logic [W-1:0] prevQ;
  logic [W-1:0] rise;

  assign rise    = cond & ~prevQ;
  assign summary = |(evQ & enQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      evQ   <= '0;
      enQ   <= '0;
    end else begin
      prevQ <= cond;
      // a fresh edge survives a clear in the same cycle
      evQ   <= (clrEv ? '0 : evQ) | rise;
      if (wrEn) enQ <= wdata;
    end
  end
endmodule

// File: rtl/status_datapath.sv
`timescale 1ns/1ps
module status_datapath
  import status_pkg::*;
#(
  parameter int STD_W  = 8,
  parameter int OPER_W = 16,
  parameter int QUES_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [STD_W-1:0]  stdCond,
  input  logic [OPER_W-1:0] operCond,
  input  logic [QUES_W-1:0] quesCond,
  input  logic              outBufNonEmpty,
  input  logic              errQueueNonEmpty,
  input  logic              rdActive,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [7:0]        statusByte,
  output logic [7:0]        srqEnMask
);
  logic [STD_W-1:0]  stdEv,  stdEn;
  logic [OPER_W-1:0] operEv, operEn;
  logic [QUES_W-1:0] quesEv, quesEn;
  logic stdSum, operSum, quesSum;
  logic [7:0] srqEnQ;
  logic [7:0] sumBits;
  logic       masterSum;

  status_event_group #(.W(STD_W)) u_std (
    .clk(clk), .rstN(rstN), .cond(stdCond),
    .clrEv(strb.rdStd || strb.clrAll), .wrEn(strb.wrStdEn),
    .wdata(hostWdata[STD_W-1:0]), .evQ(stdEv), .enQ(stdEn), .summary(stdSum));

  status_event_group #(.W(OPER_W)) u_oper (
    .clk(clk), .rstN(rstN), .cond(operCond),
    .clrEv(strb.rdOper || strb.clrAll), .wrEn(strb.wrOperEn),
    .wdata(hostWdata[OPER_W-1:0]), .evQ(operEv), .enQ(operEn), .summary(operSum));

  status_event_group #(.W(QUES_W)) u_ques (
    .clk(clk), .rstN(rstN), .cond(quesCond),
    .clrEv(strb.rdQues || strb.clrAll), .wrEn(strb.wrQuesEn),
    .wdata(hostWdata[QUES_W-1:0]), .evQ(quesEv), .enQ(quesEn), .summary(quesSum));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             srqEnQ <= '0;
    else if (strb.wrSrqEn) srqEnQ <= hostWdata[7:0] & SRQ_KEEP;
  end

  assign sumBits    = {operSum, 1'b0, stdSum, outBufNonEmpty, quesSum, errQueueNonEmpty, 2'b00};
  assign masterSum  = |(sumBits & srqEnQ);
  assign statusByte = sumBits | {1'b0, masterSum, 6'b0};
  assign srqEnMask  = srqEnQ;

  always_comb begin
    hostRdata = '0;
    if (rdActive) begin
      unique case (hostAddr)
        ADDR_STD_EV:  hostRdata = DATA_W'(stdEv);
        ADDR_OPER_EV: hostRdata = DATA_W'(operEv);
        ADDR_QUES_EV: hostRdata = DATA_W'(quesEv);
        ADDR_STD_EN:  hostRdata = DATA_W'(stdEn);
        ADDR_OPER_EN: hostRdata = DATA_W'(operEn);
        ADDR_QUES_EN: hostRdata = DATA_W'(quesEn);
        ADDR_SRQ_EN:  hostRdata = DATA_W'(srqEnQ);
        ADDR_STATUS:  hostRdata = DATA_W'(statusByte);
        default:      hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/status_report_regs.sv
`timescale 1ns/1ps
module status_report_regs
  import status_pkg::*;
#(
  parameter int STD_W  = 8,
  parameter int OPER_W = 16,
  parameter int QUES_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STD_W-1:0]  stdCond,
  input  logic [OPER_W-1:0] operCond,
  input  logic [QUES_W-1:0] quesCond,
  input  logic              outBufNonEmpty,
  input  logic              errQueueNonEmpty,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [2:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              clearAll,
  output logic [DATA_W-1:0] hostRdata,
  output logic [7:0]        statusByte
);
  strobe_t    strb;
  logic [7:0] srqEnMask;

  status_ctrl u_ctrl (
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .clearAll(clearAll), .strb(strb));

  status_datapath #(
    .STD_W(STD_W), .OPER_W(OPER_W), .QUES_W(QUES_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stdCond(stdCond), .operCond(operCond), .quesCond(quesCond),
    .outBufNonEmpty(outBufNonEmpty), .errQueueNonEmpty(errQueueNonEmpty),
    .rdActive(hostValid && !hostWrite), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .statusByte(statusByte), .srqEnMask(srqEnMask));
endmodule

// File: rtl/status_report_checker.sv
`timescale 1ns/1ps
module status_report_checker #(
  parameter int STD_W  = 8,
  parameter int OPER_W = 16,
  parameter int QUES_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [STD_W-1:0]  stdCond,
  input logic [OPER_W-1:0] operCond,
  input logic [QUES_W-1:0] quesCond,
  input logic              outBufNonEmpty,
  input logic              errQueueNonEmpty,
  input logic              hostValid,
  input logic              hostWrite,
  input logic [2:0]        hostAddr,
  input logic              clearAll,
  input logic [7:0]        statusByte,
  input logic [7:0]        srqEnMask
);
  assert_low_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[1:0] == 2'b00);

  assert_direct_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[4] == outBufNonEmpty && statusByte[2] == errQueueNonEmpty);

  assert_master_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] == |(statusByte & srqEnMask & 8'hBF));

  assert_srq_bit6_R5: assert property (@(posedge clk) disable iff (!rstN)
    srqEnMask[6] == 1'b0);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && !hostWrite && hostAddr == 3'd0 && stdCond == '0) |=> !statusByte[5]);

  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clearAll && stdCond == '0 && operCond == '0 && quesCond == '0)
      |=> (!statusByte[7] && !statusByte[5] && !statusByte[3]));
endmodule

bind status_report_regs status_report_checker #(
  .STD_W(STD_W), .OPER_W(OPER_W), .QUES_W(QUES_W)
) u_chk (
  .clk(clk), .rstN(rstN), .stdCond(stdCond), .operCond(operCond),
  .quesCond(quesCond), .outBufNonEmpty(outBufNonEmpty),
  .errQueueNonEmpty(errQueueNonEmpty), .hostValid(hostValid),
  .hostWrite(hostWrite), .hostAddr(hostAddr), .clearAll(clearAll),
  .statusByte(statusByte), .srqEnMask(srqEnMask));

// File: tb/test_status_report_regs.sv
`timescale 1ns/1ps
module test_status_report_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  stdCond = '0;
  logic [15:0] operCond = '0;
  logic [15:0] quesCond = '0;
  logic        outBufNonEmpty = 1'b0;
  logic        errQueueNonEmpty = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic        clearAll = 1'b0;
  logic [15:0] hostRdata;
  logic [7:0]  statusByte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  status_report_regs i_status_report_regs (
    .clk(clk), .rstN(rstN), .stdCond(stdCond), .operCond(operCond),
    .quesCond(quesCond), .outBufNonEmpty(outBufNonEmpty),
    .errQueueNonEmpty(errQueueNonEmpty), .hostValid(hostValid),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .clearAll(clearAll), .hostRdata(hostRdata), .statusByte(statusByte));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doRead(input logic [2:0] a, output logic [15:0] d);
    hostValid = 1'b1; hostWrite = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    step();
    hostValid = 1'b0;
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [15:0] v);
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = v;
    step();
    hostValid = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R10 status byte", 16'(statusByte), 16'h0000);
    doRead(3'd3, d); check("R10 std enable", d, 16'h0000);
    doRead(3'd6, d); check("R10 srq enable", d, 16'h0000);
    doRead(3'd1, d); check("R10 oper event", d, 16'h0000);
  endtask

  task automatic t_enables();
    logic [15:0] d;
    doWrite(3'd5, 16'hFFFF);
    doRead(3'd5, d); check("R9 ques enable full width", d, 16'hFFFF);
    doWrite(3'd3, 16'h0001);
    doWrite(3'd4, 16'h0001);
    doWrite(3'd5, 16'h0002);
    doRead(3'd3, d); check("R9 std enable", d, 16'h0001);
    doRead(3'd4, d); check("R9 oper enable", d, 16'h0001);
    doRead(3'd5, d); check("R9 ques enable", d, 16'h0002);
  endtask

  task automatic t_layout();
    stdCond = 8'h01; operCond = 16'h0001; quesCond = 16'h0002;
    step();
    check("R1 summary layout", 16'(statusByte), 16'h00A8);
    stdCond = '0; operCond = '0; quesCond = '0;
    step();
    check("R2 events sticky after fall", 16'(statusByte), 16'h00A8);
  endtask

  task automatic t_read_clear();
    logic [15:0] d;
    doRead(3'd0, d); check("R3 std read data", d, 16'h0001);
    check("R3 std cleared", 16'(statusByte), 16'h0088);
    doRead(3'd1, d); check("R3 oper read data", d, 16'h0001);
    check("R3 oper cleared", 16'(statusByte), 16'h0008);
    doRead(3'd2, d); check("R3 ques read data", d, 16'h0002);
    check("R3 ques cleared", 16'(statusByte), 16'h0000);
  endtask

  task automatic t_steady();
    logic [15:0] d;
    stdCond = 8'h04;
    step();
    doRead(3'd0, d); check("R2 edge captured", d, 16'h0004);
    step();
    doRead(3'd0, d); check("R2 steady high no re-set", d, 16'h0000);
    stdCond = '0;
    step();
  endtask

  task automatic t_collide();
    logic [15:0] d;
    stdCond = 8'h08;
    doRead(3'd0, d); check("R4 read before edge", d, 16'h0000);
    doRead(3'd0, d); check("R4 edge kept over clear", d, 16'h0008);
    stdCond = '0;
    step();
  endtask

  task automatic t_master();
    logic [15:0] d;
    doWrite(3'd6, 16'h0080);
    operCond = 16'h0001;
    step();
    check("R5 master set", 16'(statusByte), 16'h00C0);
    doWrite(3'd6, 16'h00C0);
    doRead(3'd6, d); check("R5 bit6 ignored", d, 16'h0080);
    doWrite(3'd6, 16'h0040);
    check("R5 master off via bit6 only", 16'(statusByte), 16'h0080);
    doWrite(3'd6, 16'h0080);
    check("R5 master back", 16'(statusByte), 16'h00C0);
    doWrite(3'd6, 16'h0000);
    check("R9 write zero drops master", 16'(statusByte), 16'h0080);
    doWrite(3'd6, 16'h0080);
    doRead(3'd1, d);
    check("R5 master drops with source", 16'(statusByte), 16'h0000);
    operCond = '0;
    step();
  endtask

  task automatic t_status_read();
    logic [15:0] d;
    stdCond = 8'h01;
    step();
    doWrite(3'd6, 16'h0020);
    doRead(3'd7, d); check("R6 status read data", d, 16'h0060);
    check("R6 nothing cleared", 16'(statusByte), 16'h0060);
    doRead(3'd7, d); check("R6 second read", d, 16'h0060);
    stdCond = '0;
    step();
  endtask

  task automatic t_clear_all();
    logic [15:0] d;
    operCond = 16'h0001; quesCond = 16'h0002;
    step();
    check("R7 before clear", 16'(statusByte), 16'h00E8);
    operCond = '0; quesCond = '0;
    step();
    clearAll = 1'b1;
    step();
    clearAll = 1'b0;
    check("R7 events cleared", 16'(statusByte), 16'h0000);
    doRead(3'd3, d); check("R7 std enable kept", d, 16'h0001);
    doRead(3'd6, d); check("R7 srq enable kept", d, 16'h0020);
  endtask

  task automatic t_direct();
    doWrite(3'd6, 16'h0010);
    outBufNonEmpty = 1'b1;
    #1 check("R8 message available", 16'(statusByte), 16'h0050);
    errQueueNonEmpty = 1'b1;
    #1 check("R8 error available", 16'(statusByte), 16'h0054);
    outBufNonEmpty = 1'b0;
    #1 check("R8 message drained", 16'(statusByte), 16'h0004);
    errQueueNonEmpty = 1'b0;
    #1 check("R8 errors drained", 16'(statusByte), 16'h0000);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_layout();
    t_read_clear();
    t_steady();
    t_collide();
    t_master();
    t_status_read();
    t_clear_all();
    t_direct();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule